// File: doc/BRIEF.md
# Display Test Pattern Generator

This block sits in a display output path and either forwards the incoming pixel stream or replaces it with a synthetic pattern. The patterns are a colour-square palette, alternating vertical or horizontal bars, a single or dual saturating ramp, and a solid colour. Pixel timing comes from an input strobe for active-area pixels, plus markers for the first pixel of a frame and the first pixel of a line. Each output pixel carries three 16-bit channels. Channel 0 is red or Cr and occupies pixel bits 15:0. Channel 1 is green or Y and occupies bits 31:16. Channel 2 is blue or Cb and occupies bits 47:32.

Software programs a shadow register set through a simple write port. That set is copied to the active set on the start-of-frame pixel, so a pattern change never tears part-way through a frame. A blanked flag reports that the generator is enabled and that no programmed change is still waiting for a frame start.

Top module: `pattern_gen_top`

## Requirements
- R1: While reset is held, and on the first sampled cycle after reset, pixOutValid, pixOut and blanked are all zero.
- R2: When the active enable bit is 0, each pixel presented with pixValid appears unchanged on pixOut, with pixOutValid high, one clock later. On a cycle without pixValid, pixOutValid is low one clock later and pixOut keeps its last value.
- R3: Writes go to a shadow set. The shadow set takes effect starting with the pixel that has both pixValid and pixSof. A write sets the pending flag. The frame-start copy clears it, unless a write lands in the same cycle. blanked equals active enable AND NOT pending.
- R4: Control register, address 0: bit 0 is enable, bits 3:1 are mode, bit 4 selects limited range, bits 7:5 are depth, bits 11:8 are the horizontal exponent, and bits 15:12 are the vertical exponent. Depth codes 0, 1, 2 and 3 mean 6, 8, 10 and 12 bits; any other code means 8. In every generated mode, output bits below the depth are zero.
- R5: Address 1 holds width in bits 15:0 and height in bits 31:16. Address 2 holds the X offset in bits 15:0. Addresses 3, 4 and 5 hold colour0 in bits 15:0 and colour1 in bits 31:16 for channels 0, 1 and 2. Colour bits 3:0 are always stored as zero.
- R6: Mode 0 (RGB squares): px = x + Xoffset and idx = ((px >> hexp) + (y >> vexp)) mod 8. Channel 0 is on when idx bit 2 is set, channel 1 when idx bit 1 is set, and channel 2 when idx bit 0 is set. On/off levels are 0xFFFF/0x0000 at full range and 0xEB00/0x1000 at limited range.
- R7: Modes 1 and 2 (YCbCr squares) both drive channels 0 and 2 to 0x8000. Channel 1 is at the on level when idx bit 0 is set and at the off level otherwise.
- R8: Mode 3 (vertical bars) chooses colour1 when bit 0 of (px >> hexp) is set. Mode 4 (horizontal bars) chooses colour1 when bit 0 of (y >> vexp) is set. Otherwise both modes choose colour0.
- R9: Horizontal bar mode with colour0 equal to colour1 gives one solid colour over the whole area.
- R10: Mode 5 (single ramp): every channel equals min(rampStart + (px << inc0), 0xFFFF). Address 6 holds rampStart in bits 15:0, inc0 in bits 19:16 and inc1 in bits 23:20.
- R11: Mode 6 (dual ramp): lines where bit 0 of (y >> vexp) is 0 use the first ramp. The other lines use min(px << inc1, 0xFFFF).
- R12: In generated modes, pixels with x >= width or y >= height are output as zero. The X offset shifts the pattern coordinate px.
- R13: Mode 7 forwards input pixels unchanged, as in R2, even when the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgData | input | 32 | Register write data |
| pixValid | input | 1 | Active-area pixel strobe |
| pixSof | input | 1 | First pixel of frame marker |
| pixSol | input | 1 | First pixel of line marker |
| pixIn | input | 48 | Incoming pixel, three 16-bit channels |
| pixOutValid | output | 1 | Output pixel strobe |
| pixOut | output | 48 | Output pixel, three 16-bit channels |
| blanked | output | 1 | Enabled and no update pending |

## Verification
Pixel results, both forwarded and generated, are due one clock after the pixel strobe.

The pending flag and blanked follow a write, or the start-of-frame copy, after one clock edge. A write that arrives mid-frame leaves the current frame's pixels untouched.

The bench drives inputs on the falling edge and advances its behavioural model to the state after the next rising edge. It compares every output on the following falling edge, so each cycle is checked exactly where its result is due.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int CW  = 16;
  localparam int NCH = 3;

  typedef enum logic [2:0] {
    MD_SQ_RGB = 3'd0, MD_SQ_Y601 = 3'd1, MD_SQ_Y709 = 3'd2, MD_VBAR = 3'd3,
    MD_HBAR = 3'd4, MD_RAMP1 = 3'd5, MD_RAMP2 = 3'd6, MD_FWD = 3'd7
  } mode_e;

  typedef struct packed {
    logic                    en;
    mode_e                   mode;
    logic                    limited;
    logic [2:0]              depth;
    logic [3:0]              hExp;
    logic [3:0]              vExp;
    logic [CW-1:0]           width;
    logic [CW-1:0]           height;
    logic [CW-1:0]           xOff;
    logic [NCH-1:0][CW-1:0]  col0;
    logic [NCH-1:0][CW-1:0]  col1;
    logic [CW-1:0]           rampStart;
    logic [3:0]              inc0;
    logic [3:0]              inc1;
  } cfg_t;

  typedef struct packed {
    logic          valid;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } pos_t;

  function automatic logic [CW-1:0] depthMask(logic [2:0] code);
    logic [CW-1:0] ones;
    ones = '1;
    case (code)
      3'd0:    return ~(ones >> 6);
      3'd2:    return ~(ones >> 10);
      3'd3:    return ~(ones >> 12);
      default: return ~(ones >> 8);
    endcase
  endfunction
endpackage

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgData,
  input  logic          pixValid,
  input  logic          pixSof,
  input  logic          pixSol,
  output cfg_t          effCfg,
  output pos_t          pos,
  output logic          blanked
);
  localparam logic [CW-1:0] LOW_CLR = ~{{(CW-4){1'b0}}, 4'hF};

  cfg_t          shadowCfg, activeCfg;
  logic          pending;
  logic [CW-1:0] xReg, yReg, curX, curY;
  logic          frameStart;

  assign frameStart = pixValid && pixSof;
  assign curX = (pixSof || pixSol) ? '0 : xReg + 1'b1;
  assign curY = pixSof ? '0 : (pixSol ? yReg + 1'b1 : yReg);
  assign effCfg = frameStart ? shadowCfg : activeCfg;
  assign pos = '{valid: pixValid, x: curX, y: curY};
  assign blanked = activeCfg.en && !pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= '0;
      activeCfg <= '0;
      pending   <= 1'b0;
      xReg      <= '0;
      yReg      <= '0;
    end else begin
      if (frameStart) activeCfg <= shadowCfg;
      if (cfgWe) begin
        pending <= 1'b1;
        case (cfgAddr)
          3'd0: begin
            shadowCfg.en      <= cfgData[0];
            shadowCfg.mode    <= mode_e'(cfgData[3:1]);
            shadowCfg.limited <= cfgData[4];
            shadowCfg.depth   <= cfgData[7:5];
            shadowCfg.hExp    <= cfgData[11:8];
            shadowCfg.vExp    <= cfgData[15:12];
          end
          3'd1: begin
            shadowCfg.width  <= cfgData[CW-1:0];
            shadowCfg.height <= cfgData[2*CW-1:CW];
          end
          3'd2: shadowCfg.xOff <= cfgData[CW-1:0];
          3'd6: begin
            shadowCfg.rampStart <= cfgData[CW-1:0];
            shadowCfg.inc0      <= cfgData[19:16];
            shadowCfg.inc1      <= cfgData[23:20];
          end
          default: begin
            for (int i = 0; i < NCH; i++) begin
              if (int'(cfgAddr) == 3 + i) begin
                shadowCfg.col0[i] <= cfgData[CW-1:0] & LOW_CLR;
                shadowCfg.col1[i] <= cfgData[2*CW-1:CW] & LOW_CLR;
              end
            end
          end
        endcase
      end else if (frameStart) begin
        pending <= 1'b0;
      end
      if (pixValid) begin
        xReg <= curX;
        yReg <= curY;
      end
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN) cfgWe |=> !blanked);
  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !cfgWe) |=> (blanked == activeCfg.en));
  // R3
  blank_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blanked) |-> $past(frameStart));
endmodule

// File: rtl/pgen_datapath.sv
module pgen_datapath
  import pgen_pkg::*;
#(
  parameter int PW = NCH * CW
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfg_t          cfg,
  input  pos_t          pos,
  input  logic [PW-1:0] pixIn,
  output logic          outValid,
  output logic [PW-1:0] pixOut
);
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  function automatic logic [CW-1:0] rampVal(logic [CW-1:0] base, logic [3:0] sh,
                                            logic [CW-1:0] p);
    logic [2*CW:0] sum;
    sum = {{(CW+1){1'b0}}, base} + ({{(CW+1){1'b0}}, p} << sh);
    return (sum > {{(CW+1){1'b0}}, {CW{1'b1}}}) ? {CW{1'b1}} : sum[CW-1:0];
  endfunction

  logic [CW-1:0]          px, cx, cy, onLvl, offLvl, mask, r0, r1;
  logic [2:0]             idx;
  logic                   inArea;
  logic [NCH-1:0][CW-1:0] ch;
  logic [PW-1:0]          nextPix;

  assign px     = pos.x + cfg.xOff;
  assign cx     = px >> cfg.hExp;
  assign cy     = pos.y >> cfg.vExp;
  assign idx    = cx[2:0] + cy[2:0];
  assign inArea = (pos.x < cfg.width) && (pos.y < cfg.height);
  assign onLvl  = cfg.limited ? 16'hEB00 : 16'hFFFF;
  assign offLvl = cfg.limited ? 16'h1000 : 16'h0000;
  assign mask   = depthMask(cfg.depth);
  assign r0     = rampVal(cfg.rampStart, cfg.inc0, px);
  assign r1     = rampVal('0, cfg.inc1, px);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (cfg.mode)
        MD_SQ_RGB:  ch[i] = idx[NCH-1-i] ? onLvl : offLvl;
        MD_SQ_Y601, MD_SQ_Y709:
                    ch[i] = (i == 1) ? (idx[0] ? onLvl : offLvl) : MID;
        MD_VBAR:    ch[i] = cx[0] ? cfg.col1[i] : cfg.col0[i];
        MD_HBAR:    ch[i] = cy[0] ? cfg.col1[i] : cfg.col0[i];
        MD_RAMP1:   ch[i] = r0;
        MD_RAMP2:   ch[i] = cy[0] ? r1 : r0;
        default:    ch[i] = '0;
      endcase
      if (!inArea) ch[i] = '0;
      ch[i] = ch[i] & mask;
    end
    nextPix = (!cfg.en || cfg.mode == MD_FWD) ? pixIn : ch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      pixOut   <= '0;
    end else begin
      outValid <= pos.valid;
      if (pos.valid) pixOut <= nextPix;
    end
  end

  // R2
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN) pos.valid |=> outValid);
  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pos.valid && !cfg.en) |=> (pixOut == $past(pixIn)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pos.valid |=> (!outValid && $stable(pixOut)));
  // R5
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pos.valid && cfg.en && (cfg.mode == MD_VBAR || cfg.mode == MD_HBAR))
      |=> (pixOut[3:0] == 4'h0));
endmodule

// File: rtl/pattern_gen_top.sv
module pattern_gen_top
  import pgen_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32,
  localparam int PW = NCH * CW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgData,
  input  logic          pixValid,
  input  logic          pixSof,
  input  logic          pixSol,
  input  logic [PW-1:0] pixIn,
  output logic          pixOutValid,
  output logic [PW-1:0] pixOut,
  output logic          blanked
);
  cfg_t effCfg;
  pos_t pos;

  pgen_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pixValid(pixValid), .pixSof(pixSof), .pixSol(pixSol),
    .effCfg(effCfg), .pos(pos), .blanked(blanked)
  );

  pgen_datapath #(.PW(PW)) i_dp (
    .clk(clk), .rstN(rstN), .cfg(effCfg), .pos(pos), .pixIn(pixIn),
    .outValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: tb/test_pattern_gen_top.sv
`timescale 1ns/1ps
module test_pattern_gen_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        pixValid = 1'b0, pixSof = 1'b0, pixSol = 1'b0;
  logic [47:0] pixIn = '0;
  logic        pixOutValid, blanked;
  logic [47:0] pixOut;

  always #2 clk = ~clk;

  pattern_gen_top i_pattern_gen_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pixValid(pixValid), .pixSof(pixSof), .pixSol(pixSol), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut), .blanked(blanked)
  );

  typedef struct {
    int en, mode, lim, depth, hx, vx, width, height, xoff, rs, inc0, inc1;
    int c0[3];
    int c1[3];
  } mcfg_t;

  mcfg_t       sh, ac;
  int          pend = 0, xr = 0, yr = 0, pinCnt = 1;
  logic [47:0] lastOut = '0;
  int          total = 0, bad = 0;
  string       reqTag = "R1";

  function automatic int rampE(int b, int s, int p);
    longint v;
    v = longint'(b) + (longint'(p) << s);
    return (v > 65535) ? 65535 : int'(v);
  endfunction

  function automatic logic [47:0] expPix(mcfg_t c, int x, int y, logic [47:0] pin);
    int px, cx, cy, idx, bits, mask, onL, offL, sel;
    int ch[3];
    if (c.en == 0 || c.mode == 7) return pin;          // R2 R13
    if (x >= c.width || y >= c.height) return '0;      // R12
    px = (x + c.xoff) % 65536;
    cx = px >> c.hx;
    cy = y >> c.vx;
    idx = (cx + cy) % 8;
    onL = c.lim ? 'hEB00 : 'hFFFF;
    offL = c.lim ? 'h1000 : 0;
    for (int i = 0; i < 3; i++) begin
      case (c.mode)
        0: ch[i] = ((idx >> (2 - i)) & 1) ? onL : offL;
        1, 2: ch[i] = (i == 1) ? ((idx & 1) ? onL : offL) : 32768;
        3: begin sel = cx & 1; ch[i] = sel ? c.c1[i] : c.c0[i]; end
        4: begin sel = cy & 1; ch[i] = sel ? c.c1[i] : c.c0[i]; end
        5: ch[i] = rampE(c.rs, c.inc0, px);
        default: ch[i] = (cy & 1) ? rampE(0, c.inc1, px) : rampE(c.rs, c.inc0, px);
      endcase
    end
    case (c.depth)
      0: bits = 6; 2: bits = 10; 3: bits = 12; default: bits = 8;
    endcase
    mask = 65535 & ~(65535 >> bits);
    return {16'(ch[2] & mask), 16'(ch[1] & mask), 16'(ch[0] & mask)};
  endfunction

  task automatic mwrite(int a, logic [31:0] d);
    case (a)
      0: begin sh.en = d[0]; sh.mode = d[3:1]; sh.lim = d[4]; sh.depth = d[7:5];
               sh.hx = d[11:8]; sh.vx = d[15:12]; end
      1: begin sh.width = d[15:0]; sh.height = d[31:16]; end
      2: sh.xoff = d[15:0];
      3, 4, 5: begin sh.c0[a-3] = d[15:0] & 16'hFFF0; sh.c1[a-3] = d[31:16] & 16'hFFF0; end
      6: begin sh.rs = d[15:0]; sh.inc0 = d[19:16]; sh.inc1 = d[23:20]; end
      default: ;
    endcase
  endtask

  task automatic step(bit we, int a, logic [31:0] d, bit v, bit sof, bit sol);
    mcfg_t e;
    int cx_, cy_, expB;
    logic [47:0] pin;
    pin = {16'(pinCnt) ^ 16'h5A5A, 16'(pinCnt * 3), ~16'(pinCnt)};
    pinCnt++;
    cfgWe = we; cfgAddr = 3'(a); cfgData = d;
    pixValid = v; pixSof = sof; pixSol = sol; pixIn = pin;
    e = (v && sof) ? sh : ac;
    cx_ = (sof || sol) ? 0 : (xr + 1) % 65536;
    cy_ = sof ? 0 : (sol ? (yr + 1) % 65536 : yr);
    if (v) lastOut = expPix(e, cx_, cy_, pin);
    if (v && sof) ac = sh;
    if (we) begin mwrite(a, d); pend = 1; end
    else if (v && sof) pend = 0;
    if (v) begin xr = cx_; yr = cy_; end
    expB = (ac.en != 0 && pend == 0) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (pixOutValid !== v || pixOut !== lastOut || blanked !== expB[0]) begin
      bad++;
      $display("FAIL %s: valid=%b/%b pix=%h/%h blanked=%b/%0d (act/exp)",
               reqTag, pixOutValid, v, pixOut, lastOut, blanked, expB);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic frame(int w, int h, bit midWr, int a, logic [31:0] d);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) step(1'b0, 0, 0, 1'b1, x == 0 && y == 0, x == 0 && y > 0);
      if (midWr && y == 0) wr(a, d);
      else step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  function automatic logic [31:0] ctl(int en, int md, int lim, int dep, int hx, int vx);
    return 32'(en | (md << 1) | (lim << 4) | (dep << 5) | (hx << 8) | (vx << 12));
  endfunction

  bit done = 0;

  initial begin
    sh = '{default: 0, c0: '{0, 0, 0}, c1: '{0, 0, 0}};
    ac = sh;
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (pixOutValid !== 0 || pixOut !== '0 || blanked !== 0) begin
      bad++; $display("FAIL R1: valid=%b pix=%h blanked=%b exp 0/0/0", pixOutValid, pixOut, blanked);
    end
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (pixOutValid !== 0 || pixOut !== '0 || blanked !== 0) begin
      bad++; $display("FAIL R1: after reset valid=%b pix=%h blanked=%b exp 0", pixOutValid, pixOut, blanked);
    end
    reqTag = "R2"; frame(6, 3, 0, 0, 0);
    // R3: mid-frame write does not touch the current frame
    reqTag = "R3";
    wr(1, {16'd3, 16'd6});
    wr(3, {16'hFFFF, 16'h1234});
    wr(4, {16'h0000, 16'hABCD});
    wr(5, {16'h8888, 16'h0F0F});
    frame(6, 3, 1, 0, ctl(1, 3, 0, 3, 0, 0));
    frame(6, 3, 0, 0, 0);
    // R5 colour low bits cleared, 12-bit depth
    reqTag = "R5"; frame(6, 3, 0, 0, 0);
    // R4 depth codes
    reqTag = "R4";
    wr(0, ctl(1, 3, 0, 0, 1, 0)); frame(6, 2, 0, 0, 0);
    wr(0, ctl(1, 3, 0, 5, 1, 0)); frame(6, 2, 0, 0, 0);
    wr(0, ctl(1, 3, 0, 2, 1, 0)); frame(6, 2, 0, 0, 0);
    // R8 bars
    reqTag = "R8";
    wr(0, ctl(1, 4, 0, 3, 0, 0)); frame(4, 3, 0, 0, 0);
    wr(0, ctl(1, 4, 0, 1, 0, 1)); wr(1, {16'd4, 16'd4}); frame(4, 4, 0, 0, 0);
    // R9 solid
    reqTag = "R9";
    wr(3, {16'h7770, 16'h7770}); wr(4, {16'h1110, 16'h1110}); wr(5, {16'hC0C0, 16'hC0C0});
    wr(0, ctl(1, 4, 0, 3, 0, 0)); frame(5, 4, 0, 0, 0);
    // R6 RGB squares, full and limited
    reqTag = "R6";
    wr(1, {16'd4, 16'd8}); wr(0, ctl(1, 0, 0, 1, 1, 1)); frame(8, 4, 0, 0, 0);
    wr(0, ctl(1, 0, 1, 0, 0, 0)); frame(8, 2, 0, 0, 0);
    // R7 YCbCr squares
    reqTag = "R7";
    wr(0, ctl(1, 1, 0, 3, 0, 1)); frame(4, 4, 0, 0, 0);
    wr(0, ctl(1, 2, 1, 1, 1, 0)); frame(4, 2, 0, 0, 0);
    // R10 single ramp with saturation
    reqTag = "R10";
    wr(6, 32'h00D_4000); wr(0, ctl(1, 5, 0, 3, 0, 0)); frame(8, 2, 0, 0, 0);
    // R11 dual ramp
    reqTag = "R11";
    wr(6, {8'h0, 4'd8, 4'd6, 16'h6000}); wr(0, ctl(1, 6, 0, 2, 0, 0)); frame(8, 4, 0, 0, 0);
    // R12 offset and active area
    reqTag = "R12";
    wr(3, {16'hFFFF, 16'h0000}); wr(1, {16'd2, 16'd4}); wr(2, 32'd2);
    wr(0, ctl(1, 3, 0, 1, 1, 0)); frame(6, 3, 0, 0, 0);
    // R13 reserved mode forwards
    reqTag = "R13";
    wr(0, ctl(1, 7, 0, 1, 0, 0)); frame(4, 2, 0, 0, 0);
    // R2 disable again
    reqTag = "R2";
    wr(0, 32'd0); frame(4, 2, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule